// File: doc/BRIEF.md
# Three-Wire Control Register Slave

This block is the slave end of a three-wire control link. The link has an active-low select, a serial clock and one bidirectional data line. Through it a host reads and writes a bank of 18-bit control registers, each picked by a 5-bit address. A frame begins when select falls. The host sends a direction bit, then five address bits, then eighteen data bits. On a write it supplies the data bits. On a read the slave takes over the data line for the data phase and shifts the addressed register back to the host.

The block runs on a local reference clock and oversamples the three link pins through synchronisers. All edge handling is therefore synchronous to that clock. The bidirectional pin is split into an input, an output and an output enable, and the pad combines them outside the block.

A write commits only on the closing clock edge of a complete frame, so a frame cut short changes nothing. A write to any synthesiser register (addresses 1 to 7) starts a recalibration pulse that is held for a set number of reference clock cycles. A write to the all-ones address is a soft reset. It restores every register to its default when select next rises.

The frame controller has five states:
- `ST_IDLE`: select is high.
- `ST_HEADER`: the direction and address bits are being shifted in.
- `ST_WDATA`: a write data phase is in progress.
- `ST_RDATA`: a read data phase is in progress and the slave drives the line.
- `ST_DONE`: a write has committed, and any further clocks are ignored.

The transitions are:
- `ST_IDLE` to `ST_HEADER` when select falls.
- `ST_HEADER` to `ST_RDATA` or `ST_WDATA` on the sixth rising clock edge, chosen by the direction bit.
- `ST_WDATA` to `ST_DONE` on the falling clock edge after the 24th bit.
- Any state to `ST_IDLE` whenever select is high.

Top module: `serial_ctrl_regs`

## Requirements
- R1: A frame is sent MSB first and sampled on rising clock edges. Bit 1 is the direction (1 = read, 0 = write), bits 2 to 6 are the address (MSB first), and bits 7 to 24 are the register data (bit 17 first).
- R2: A write updates the addressed register on the falling clock edge that follows the 24th rising edge. A later read of that address returns the written value.
- R3: If select rises before that final falling edge, no register changes.
- R4: `sdio_oe` is asserted only during the data phase of a read. The first data bit (bit 17) is driven after the falling edge that follows the last address bit, and each later falling edge moves on to the next lower bit. `sdio_oe` is never asserted during a write frame.
- R5: `sdio_oe` is low whenever `sel_n` is high, including in the same instant that select rises.
- R6: After reset the registers hold their defaults: address 0 = 00007h, 1 = 09003h, 2 = 00022h, 3 = 1FF78h, 4 = 09003h, 5 = 01780h, 7 = 14578h, 8 = 1E742h, 9 = 00120h, and 0 for addresses 6, 10, 11 and 12.
- R7: A complete write to address 31 restores all registers to the R6 defaults when select next rises. The data bits of that write are ignored. An incomplete frame to address 31 has no effect.
- R8: A committed write to an address from 1 to 7 drives `recal_pulse` high for exactly RECAL_CYCLES clock cycles (4 by default). A write to any other address leaves `recal_pulse` low.
- R9: Addresses from 13 to 30 are unimplemented. They read as zero, and writes to them are discarded.
- R10: Clock pulses after the 24th bit of a frame, while select stays low, do not change the value written.
- R11: The bit counter clears while select is high, so a frame that follows an aborted one is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also sets the recalibration pulse unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Input side of the data pad |
| sdio_out | output | 1 | Output side of the data pad |
| sdio_oe | output | 1 | Pad drive enable; high only during a read data phase |
| recal_pulse | output | 1 | Recalibration request to the synthesiser |

## Verification
The bench attacks frame boundaries:
- A write cut off one bit short must leave the target register untouched. A design that committed early would corrupt it.
- A frame padded with extra clocks must store its own 18 data bits. A design that kept shifting would store the trailing ones instead.
- A soft reset frame that is cut short must not reset the bank. A design that decoded address 31 early would wipe the registers.

It also checks read turnaround. The data must start one clock after the last address bit, and a design that was off by one edge would return the register shifted by one bit. The drive must also end when select rises, and a design that failed to release the line would collide with the host. Finally, the bench counts the length of the recalibration pulse for synthesiser and non-synthesiser addresses, which catches a pulse that is missing, one that fires on the wrong address, or one of the wrong width.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 18;
    localparam int HDR_W     = 1 + ADDR_W;
    localparam int FRAME_W   = HDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int SRST_ADDR = (1 << ADDR_W) - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_WDATA,
        ST_RDATA,
        ST_DONE
    } frame_state_e;

    // Power-on value of each implemented register, built from its field defaults
    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 18'h00007;
            1:       return 18'h09003;
            2:       return 18'h00022;
            3:       return 18'h1FF78;
            4:       return 18'h09003;
            5:       return 18'h01780;
            7:       return 18'h14578;
            8:       return 18'h1E742;
            9:       return 18'h00120;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_active,
    output logic              sdo,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [DATA_W-1:0] commit_data,
    output logic              srst_pulse,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0]  CNT_HDR  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [ADDR_W-1:0] A_SRST   = ADDR_W'(SRST_ADDR);

    frame_state_e state, state_nx;
    logic sclk_d, sel_d;
    logic [HDR_W-1:0]  hdr_sh;
    logic [DATA_W-1:0] wr_sh, out_sh;
    logic loaded, srst_pend;

    wire sclk_rise = sclk_s & ~sclk_d;
    wire sclk_fall = ~sclk_s & sclk_d;
    wire sel_rise  = sel_n_s & ~sel_d;
    wire last_fall = sclk_fall && (state == ST_WDATA) && (bit_cnt == CNT_FULL);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (sel_n_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_HEADER;
                ST_HEADER: if (sclk_rise && bit_cnt == CNT_HDR - 1'b1)
                               state_nx = hdr_sh[HDR_W-2] ? ST_RDATA : ST_WDATA;
                ST_WDATA:  if (last_fall) state_nx = ST_DONE;
                ST_RDATA:  state_nx = ST_RDATA;
                ST_DONE:   state_nx = ST_DONE;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d      <= 1'b0;
            sel_d       <= 1'b1;
            bit_cnt     <= '0;
            hdr_sh      <= '0;
            wr_sh       <= '0;
            out_sh      <= '0;
            loaded      <= 1'b0;
            commit_en   <= 1'b0;
            commit_addr <= '0;
            commit_data <= '0;
            srst_pend   <= 1'b0;
            srst_pulse  <= 1'b0;
        end else begin
            sclk_d     <= sclk_s;
            sel_d      <= sel_n_s;
            commit_en  <= 1'b0;
            srst_pulse <= sel_rise && srst_pend;
            if (sel_rise) srst_pend <= 1'b0;
            if (sel_n_s) begin
                bit_cnt <= '0;
                loaded  <= 1'b0;
            end else begin
                if (sclk_rise && bit_cnt < CNT_FULL) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt < CNT_HDR) hdr_sh <= {hdr_sh[HDR_W-2:0], sdi_s};
                    else                   wr_sh  <= {wr_sh[DATA_W-2:0], sdi_s};
                end
                if (sclk_fall && state == ST_RDATA && bit_cnt < CNT_FULL) begin
                    loaded <= 1'b1;
                    out_sh <= loaded ? {out_sh[DATA_W-2:0], 1'b0} : rd_data;
                end
                if (last_fall) begin
                    commit_en   <= (hdr_sh[ADDR_W-1:0] != A_SRST);
                    commit_addr <= hdr_sh[ADDR_W-1:0];
                    commit_data <= wr_sh;
                    if (hdr_sh[ADDR_W-1:0] == A_SRST) srst_pend <= 1'b1;
                end
            end
        end
    end

    assign rd_addr   = hdr_sh[ADDR_W-1:0];
    assign rd_active = (state == ST_RDATA);
    assign sdo       = out_sh[DATA_W-1];
endmodule

// File: rtl/tw_regbank.sv
module tw_regbank
    import tw_pkg::*;
#(
    parameter int NUM_REGS     = 13,
    parameter int RECAL_CYCLES = 4,
    parameter int SYN_FIRST    = 1,
    parameter int SYN_LAST     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              srst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              recal
);
    localparam int RC_W = $clog2(RECAL_CYCLES + 1);

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [RC_W-1:0]   rc_cnt;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                   regs[g] <= reg_default(g);
                else if (srst)                                regs[g] <= reg_default(g);
                else if (wr_en && wr_addr == ADDR_W'(g))      regs[g] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
    end

    wire syn_hit = wr_en && (wr_addr >= ADDR_W'(SYN_FIRST)) && (wr_addr <= ADDR_W'(SYN_LAST));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            rc_cnt <= '0;
        else if (syn_hit)      rc_cnt <= RC_W'(RECAL_CYCLES);
        else if (rc_cnt != '0) rc_cnt <= rc_cnt - 1'b1;
    end

    assign recal = (rc_cnt != '0);
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
    import tw_pkg::*;
#(
    parameter int NUM_REGS     = 13,
    parameter int RECAL_CYCLES = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int SYN_FIRST    = 1,
    parameter int SYN_LAST     = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic sclk,
    input  logic sdio_in,
    output logic sdio_out,
    output logic sdio_oe,
    output logic recal_pulse
);
    logic              sel_sync, sclk_sync, sdi_sync;
    logic [ADDR_W-1:0] rd_addr, commit_addr;
    logic [DATA_W-1:0] rd_data, commit_data;
    logic              rd_active, sdo, commit_en, srst_pulse;
    logic [CNT_W-1:0]  frame_bits;

    tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, sclk, sdio_in}),
        .q     ({sel_sync, sclk_sync, sdi_sync})
    );

    tw_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n_s     (sel_sync),
        .sclk_s      (sclk_sync),
        .sdi_s       (sdi_sync),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .rd_active   (rd_active),
        .sdo         (sdo),
        .commit_en   (commit_en),
        .commit_addr (commit_addr),
        .commit_data (commit_data),
        .srst_pulse  (srst_pulse),
        .bit_cnt     (frame_bits)
    );

    tw_regbank #(
        .NUM_REGS     (NUM_REGS),
        .RECAL_CYCLES (RECAL_CYCLES),
        .SYN_FIRST    (SYN_FIRST),
        .SYN_LAST     (SYN_LAST)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_addr (commit_addr),
        .wr_data (commit_data),
        .srst    (srst_pulse),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .recal   (recal_pulse)
    );

    // Drive is cut straight from the raw select so the pad frees at once
    assign sdio_oe  = rd_active & ~sel_n;
    assign sdio_out = sdo & sdio_oe;
endmodule

// File: rtl/serial_ctrl_regs_chk.sv
module serial_ctrl_regs_chk
    import tw_pkg::*;
#(
    parameter int RECAL_CYCLES = 4,
    parameter int SYN_FIRST    = 1,
    parameter int SYN_LAST     = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sdio_oe,
    input logic              recal_pulse,
    input logic              commit_en,
    input logic [ADDR_W-1:0] commit_addr,
    input logic [CNT_W-1:0]  frame_bits,
    input logic              srst_pulse,
    input logic              sel_sync
);
    logic [15:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hi_run <= '0;
        else if (recal_pulse) hi_run <= hi_run + 16'd1;
        else                  hi_run <= '0;
    end

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !sdio_oe);

    // R4
    oe_after_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdio_oe |-> (frame_bits >= CNT_W'(HDR_W)));

    // R2
    commit_full_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (frame_bits == CNT_W'(FRAME_W)));

    // R7
    srst_on_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pulse |-> sel_sync);

    // R8
    recal_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recal_pulse) |-> ($past(commit_en)
                                && $past(commit_addr) >= ADDR_W'(SYN_FIRST)
                                && $past(commit_addr) <= ADDR_W'(SYN_LAST)));

    // R8
    recal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recal_pulse) |-> (hi_run >= 16'(RECAL_CYCLES)));
endmodule

bind serial_ctrl_regs serial_ctrl_regs_chk #(
    .RECAL_CYCLES (RECAL_CYCLES),
    .SYN_FIRST    (SYN_FIRST),
    .SYN_LAST     (SYN_LAST)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n       (sel_n),
    .sdio_oe     (sdio_oe),
    .recal_pulse (recal_pulse),
    .commit_en   (commit_en),
    .commit_addr (commit_addr),
    .frame_bits  (frame_bits),
    .srst_pulse  (srst_pulse),
    .sel_sync    (sel_sync)
);

// File: tb/test_serial_ctrl_regs.sv
`timescale 1ns/1ps
module test_serial_ctrl_regs;
    localparam int RECAL = 4;
    localparam int HALF  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, recal_pulse;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int recal_cnt = 0;

    logic [17:0] exp_q [$];
    string       req_q [$];
    logic [17:0] act_q [$];

    always #2.5 clk = ~clk;

    serial_ctrl_regs #(.RECAL_CYCLES(RECAL)) i_serial_ctrl_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_n       (sel_n),
        .sclk        (sclk),
        .sdio_in     (sdio_in),
        .sdio_out    (sdio_out),
        .sdio_oe     (sdio_oe),
        .recal_pulse (recal_pulse)
    );

    always @(negedge clk) if (recal_pulse) recal_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each captured read against its expectation
    initial begin
        forever begin
            @(negedge clk);
            if (act_q.size() != 0 && exp_q.size() != 0) begin
                logic [17:0] a, e;
                string r;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(a === e, r, int'(a), int'(e));
            end
        end
    end

    task automatic frame(input bit rw, input logic [4:0] addr, input logic [17:0] data,
                         input int nbits, output logic [17:0] got, output bit oe_bad);
        logic [23:0] f;
        f = {rw, addr, data};
        got = '0;
        oe_bad = 1'b0;
        sel_n = 1'b0;
        #HALF;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdio_in = (i < 24) ? f[23-i] : 1'b1;
            #HALF;
            if (rw && i >= 6 && i < 24) begin
                got[23-i] = sdio_out;
                if (sdio_oe !== 1'b1) oe_bad = 1'b1;
            end else if (!rw && sdio_oe !== 1'b0) begin
                oe_bad = 1'b1;
            end
            sclk = 1'b1;
            #HALF;
        end
        sclk = 1'b0;
        #HALF;
        sel_n = 1'b1;
        #1;
        // R5: pad drive must be off as soon as select is high
        check(sdio_oe === 1'b0, "R5", int'(sdio_oe), 0);
        #(2 * HALF);
    endtask

    task automatic wr(input logic [4:0] addr, input logic [17:0] data, input int nbits);
        logic [17:0] g;
        bit bad;
        frame(1'b0, addr, data, nbits, g, bad);
        // R4: no drive in a write frame
        check(!bad, "R4", int'(bad), 0);
    endtask

    task automatic rd(input logic [4:0] addr, input logic [17:0] exp, input string req);
        logic [17:0] g;
        bit bad;
        exp_q.push_back(exp);
        req_q.push_back(req);
        frame(1'b1, addr, 18'h0, 24, g, bad);
        act_q.push_back(g);
        // R4: drive held through the whole read data phase
        check(!bad, "R4", int'(bad), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R6 / R5: idle outputs after reset
        check(sdio_oe === 1'b0 && recal_pulse === 1'b0, "R6", int'({sdio_oe, recal_pulse}), 0);

        // R6 defaults
        rd(5'd0, 18'h00007, "R6");
        rd(5'd8, 18'h1E742, "R6");
        rd(5'd9, 18'h00120, "R6");
        rd(5'd7, 18'h14578, "R6");

        // R1 / R2 write then read
        wr(5'd9, 18'h2A5C3, 24);
        rd(5'd9, 18'h2A5C3, "R2");
        wr(5'd12, 18'h3FFFF, 24);
        rd(5'd12, 18'h3FFFF, "R1");

        // R3 aborted frame; R11 following frame decoded afresh
        wr(5'd9, 18'h11111, 23);
        rd(5'd9, 18'h2A5C3, "R3");
        wr(5'd10, 18'h00F0F, 10);
        wr(5'd10, 18'h15A5A, 24);
        rd(5'd10, 18'h15A5A, "R11");

        // R9 unimplemented address
        wr(5'd20, 18'h3ABCD, 24);
        rd(5'd20, 18'h00000, "R9");

        // R8 recalibration pulse
        recal_cnt = 0;
        wr(5'd4, 18'h0ABCD, 24);
        check(recal_cnt == RECAL, "R8", recal_cnt, RECAL);
        recal_cnt = 0;
        wr(5'd9, 18'h2A5C3, 24);
        check(recal_cnt == 0, "R8", recal_cnt, 0);
        rd(5'd4, 18'h0ABCD, "R2");

        // R10 extra clocks after bit 24
        wr(5'd11, 18'h0F0F0, 30);
        rd(5'd11, 18'h0F0F0, "R10");

        // R7 aborted soft reset then full soft reset
        wr(5'd31, 18'h00000, 20);
        rd(5'd9, 18'h2A5C3, "R7");
        wr(5'd31, 18'h3FFFF, 24);
        rd(5'd9, 18'h00120, "R7");
        rd(5'd12, 18'h00000, "R7");
        rd(5'd4, 18'h09003, "R7");
        rd(5'd0, 18'h00007, "R7");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule